// File: doc/BRIEF.md
# Serial Configuration Register Port

This block lets an external host read and write a small bank of 8-bit configuration registers over a serial link. Every access is framed by an active-low select. While the select is low the host sends 16 clock pulses. The first 8 bits form an instruction: a read flag and a register address. The next 8 bits carry the data. On a write the host sends those bits. On a read the block returns them.

The serial clock and select are oversampled by the chip clock, and the block works from the rising and falling edges of the serial clock. Host data is taken on each rising edge. Read data is changed after each falling edge, so the host can take it on the next rising edge.

The control register at address 0 holds three controls for the port itself:
- the choice of pin wiring, either one shared data pin or a separate output pin;
- the shift order;
- a software reset that clears itself.

Two further registers each hold a 6-bit gain code and a bit that selects that code over external gain pins. These fields are brought out to the rest of the chip.

Top module: `spi_cfg_port`

## Requirements
- R1: While rst_n is low, and right after it, sdio_oe and sdo_oe are 0, and every register holds its default. The default is 0 for the control register and for both select bits. The gain codes default to the parameters RX_GAIN_RST and TX_GAIN_RST.
- R2: A write commits on the 16th rising edge of spi_sclk while spi_sen_n is low. Instruction bit 7 = 1 means read and 0 means write. Instruction bits ADDR_W-1:0 give the address, and bits 6:ADDR_W are ignored. The data byte follows the instruction.
- R3: On a read, the block drives one data bit after each falling edge, starting with the falling edge after the 8th rising edge. The host takes the bits on rising edges 9 to 16. The output stays steady between falling edges.
- R4: With control bit 7 = 0 (3-wire), sdio_oe is high only during the data phase of a read, and sdo_oe stays low. Both enables drop within one clock after spi_sen_n goes high.
- R5: With control bit 7 = 1 (4-wire), sdo_oe is high only during the data phase of a read, and sdio_oe is never high. Input data still arrives on sdio_in.
- R6: With control bit 6 = 1, the instruction and the data are both sent and received least significant bit first. With bit 6 = 0, the most significant bit comes first.
- R7: Writing 1 to control bit 5 returns all registers to their defaults on the next clock. The bit then reads back as 0.
- R8: Register bits that have no function are stored as 0 and read as 0. Those bits are control bits 4:0 and bit 7 of the gain registers. Addresses other than 0, 9 and 10 read 0 and ignore writes.
- R9: If spi_sen_n rises before the 16th rising edge, no register changes. Registers never change while spi_sen_n has been high for two clocks or more.
- R10: Register 9 drives the receive outputs: rx_gain_sel from bit 6 and rx_gain_code from bits 5:0. Register 10 drives tx_gain_sel and tx_gain_code from the same bit positions.
- R11: Clock pulses after the 16th rising edge of an access have no effect until spi_sen_n goes high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sen_n | input | 1 | Active-low access select |
| spi_sclk | input | 1 | Serial clock from the host |
| sdio_in | input | 1 | Data pin input (host to block) |
| sdio_out | output | 1 | Data pin output value in 3-wire mode |
| sdio_oe | output | 1 | Data pin output enable (3-wire read) |
| sdo_out | output | 1 | Separate output pin value in 4-wire mode |
| sdo_oe | output | 1 | Separate output pin enable (4-wire read) |
| rx_gain_sel | output | 1 | Use the register-held receive gain |
| rx_gain_code | output | GAIN_W | Receive gain code |
| tx_gain_sel | output | 1 | Use the register-held transmit gain |
| tx_gain_code | output | GAIN_W | Transmit gain code |

## Verification
The hardest situations to reach are reads taken after the port has changed its own pin wiring or shift order. A software reset can also put the port back into 3-wire, MSB-first mode, and the host must follow that change. The stimulus writes random values to the control register mixed with gain-register traffic. A bench model tracks which pin and which bit order apply to each access, so every later read is checked under the mode that write left behind. Directed accesses cut off after 12 and 15 edges, and others run on to 20 edges, to cover the abort and overrun cases.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
   localparam int unsigned REG_W    = 8;
   localparam int unsigned INSTR_W  = 8;
   localparam int unsigned CTL_ADDR = 0;
   localparam int unsigned RXG_ADDR = 9;
   localparam int unsigned TXG_ADDR = 10;
   localparam int unsigned BIT_4W   = 7;
   localparam int unsigned BIT_LSB  = 6;
   localparam int unsigned BIT_SRST = 5;

   // Implemented bits of each address; zero means no storage at all.
   function automatic logic [REG_W-1:0] reg_mask(int unsigned a, int unsigned gw);
      logic [REG_W-1:0] m;
      m = '0;
      if (a == CTL_ADDR) begin
         m[BIT_4W]   = 1'b1;
         m[BIT_LSB]  = 1'b1;
         m[BIT_SRST] = 1'b1;
      end else if (a == RXG_ADDR || a == TXG_ADDR) begin
         m = REG_W'((1 << (gw + 1)) - 1);
      end
      return m;
   endfunction

   function automatic logic [REG_W-1:0] bitrev(logic [REG_W-1:0] v);
      logic [REG_W-1:0] r;
      for (int i = 0; i < int'(REG_W); i++) r[i] = v[REG_W-1-i];
      return r;
   endfunction
endpackage

// File: rtl/spi_cfg_edges.sv
module spi_cfg_edges (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk,
   output logic rise,
   output logic fall
);
   logic sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_q <= 1'b0;
      else        sclk_q <= sclk;
   end

   assign rise = sclk & ~sclk_q;
   assign fall = ~sclk & sclk_q;
endmodule

// File: rtl/spi_cfg_shift.sv
module spi_cfg_shift
   import spi_cfg_pkg::*;
#(
   parameter int unsigned ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sen_n,
   input  logic              sclk_rise,
   input  logic              sclk_fall,
   input  logic              din,
   input  logic              lsb_first,
   input  logic [REG_W-1:0]  rd_data,
   output logic              wr_en,
   output logic [ADDR_W-1:0] addr,
   output logic [REG_W-1:0]  wr_data,
   output logic              dout,
   output logic              drive
);
   localparam int unsigned TOTAL = INSTR_W + REG_W;
   localparam int unsigned CNT_W = $clog2(TOTAL + 1);
   localparam logic [CNT_W-1:0] LAST_INSTR = CNT_W'(INSTR_W - 1);
   localparam logic [CNT_W-1:0] FIRST_DATA = CNT_W'(INSTR_W);
   localparam logic [CNT_W-1:0] LAST_BIT   = CNT_W'(TOTAL - 1);
   localparam logic [CNT_W-1:0] DONE       = CNT_W'(TOTAL);

   logic [CNT_W-1:0]  cnt;
   logic [REG_W-1:0]  sh;
   logic [REG_W-1:0]  tx_q;
   logic [ADDR_W-1:0] addr_q;
   logic              is_rd;
   logic              drive_q;
   logic [REG_W-1:0]  sh_next;
   logic [REG_W-1:0]  ordered;
   logic              take;

   assign sh_next = {sh[REG_W-2:0], din};
   assign ordered = lsb_first ? bitrev(sh_next) : sh_next;
   assign take    = sclk_rise & ~sen_n & (cnt != DONE);

   assign wr_en   = take & (cnt == LAST_BIT) & ~is_rd;
   assign wr_data = ordered;
   assign addr    = addr_q;
   assign dout    = tx_q[REG_W-1];
   assign drive   = drive_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         sh      <= '0;
         tx_q    <= '0;
         addr_q  <= '0;
         is_rd   <= 1'b0;
         drive_q <= 1'b0;
      end else if (sen_n) begin
         cnt     <= '0;
         is_rd   <= 1'b0;
         drive_q <= 1'b0;
      end else begin
         if (take) begin
            sh  <= sh_next;
            cnt <= cnt + 1'b1;
            if (cnt == LAST_INSTR) begin
               is_rd  <= ordered[INSTR_W-1];
               addr_q <= ordered[ADDR_W-1:0];
            end
         end
         if (sclk_fall && is_rd) begin
            if (cnt == FIRST_DATA) begin
               tx_q    <= lsb_first ? bitrev(rd_data) : rd_data;
               drive_q <= 1'b1;
            end else if (drive_q && cnt != DONE) begin
               tx_q <= {tx_q[REG_W-2:0], 1'b0};
            end
         end
      end
   end
endmodule

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
   import spi_cfg_pkg::*;
#(
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned GAIN_W      = 6,
   parameter logic [GAIN_W-1:0] RX_GAIN_RST = '0,
   parameter logic [GAIN_W-1:0] TX_GAIN_RST = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  wr_data,
   output logic [REG_W-1:0]  rd_data,
   output logic [REG_W-1:0]  ctl_q,
   output logic [REG_W-1:0]  rxg_q,
   output logic [REG_W-1:0]  txg_q,
   output logic              srst
);
   localparam int unsigned NREG = 1 << ADDR_W;

   function automatic logic [REG_W-1:0] def_of(int unsigned a);
      if (a == RXG_ADDR) return REG_W'(RX_GAIN_RST);
      if (a == TXG_ADDR) return REG_W'(TX_GAIN_RST);
      return '0;
   endfunction

   logic [REG_W-1:0] regs_q [NREG];

   assign srst = regs_q[CTL_ADDR][BIT_SRST];

   for (genvar i = 0; i < int'(NREG); i++) begin : g_reg
      localparam logic [REG_W-1:0] MASK = reg_mask(i, GAIN_W);
      localparam logic [REG_W-1:0] DEF  = def_of(i);
      if (MASK != '0) begin : g_flop
         logic [REG_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                q <= DEF;
            else if (srst)                             q <= DEF;
            else if (wr_en && addr == ADDR_W'(i))      q <= wr_data & MASK;
         end
         assign regs_q[i] = q;
      end else begin : g_none
         assign regs_q[i] = '0;
      end
   end

   assign rd_data = regs_q[addr];
   assign ctl_q   = regs_q[CTL_ADDR];
   assign rxg_q   = regs_q[RXG_ADDR];
   assign txg_q   = regs_q[TXG_ADDR];
endmodule

// File: rtl/spi_cfg_port.sv
module spi_cfg_port
   import spi_cfg_pkg::*;
#(
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned GAIN_W      = 6,
   parameter logic [GAIN_W-1:0] RX_GAIN_RST = '0,
   parameter logic [GAIN_W-1:0] TX_GAIN_RST = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sen_n,
   input  logic              spi_sclk,
   input  logic              sdio_in,
   output logic              sdio_out,
   output logic              sdio_oe,
   output logic              sdo_out,
   output logic              sdo_oe,
   output logic              rx_gain_sel,
   output logic [GAIN_W-1:0] rx_gain_code,
   output logic              tx_gain_sel,
   output logic [GAIN_W-1:0] tx_gain_code
);
   if (ADDR_W < 4 || ADDR_W > INSTR_W - 1) begin : g_bad_addr
      $error("ADDR_W must reach address 10 and leave room for the read flag");
   end
   if (GAIN_W + 1 > REG_W) begin : g_bad_gain
      $error("GAIN_W plus its select bit must fit in one register");
   end

   logic              sclk_rise;
   logic              sclk_fall;
   logic              wr_en;
   logic              srst;
   logic              dout;
   logic              drive;
   logic [ADDR_W-1:0] addr;
   logic [REG_W-1:0]  wr_data;
   logic [REG_W-1:0]  rd_data;
   logic [REG_W-1:0]  ctl_q;
   logic [REG_W-1:0]  rxg_q;
   logic [REG_W-1:0]  txg_q;

   spi_cfg_edges u_edges (
      .clk  (clk),
      .rst_n(rst_n),
      .sclk (spi_sclk),
      .rise (sclk_rise),
      .fall (sclk_fall)
   );

   spi_cfg_shift #(.ADDR_W(ADDR_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .sen_n    (spi_sen_n),
      .sclk_rise(sclk_rise),
      .sclk_fall(sclk_fall),
      .din      (sdio_in),
      .lsb_first(ctl_q[BIT_LSB]),
      .rd_data  (rd_data),
      .wr_en    (wr_en),
      .addr     (addr),
      .wr_data  (wr_data),
      .dout     (dout),
      .drive    (drive)
   );

   spi_cfg_regs #(
      .ADDR_W     (ADDR_W),
      .GAIN_W     (GAIN_W),
      .RX_GAIN_RST(RX_GAIN_RST),
      .TX_GAIN_RST(TX_GAIN_RST)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .addr   (addr),
      .wr_data(wr_data),
      .rd_data(rd_data),
      .ctl_q  (ctl_q),
      .rxg_q  (rxg_q),
      .txg_q  (txg_q),
      .srst   (srst)
   );

   assign sdio_oe      = drive & ~ctl_q[BIT_4W];
   assign sdo_oe       = drive &  ctl_q[BIT_4W];
   assign sdio_out     = sdio_oe & dout;
   assign sdo_out      = sdo_oe & dout;
   assign rx_gain_sel  = rxg_q[GAIN_W];
   assign rx_gain_code = rxg_q[GAIN_W-1:0];
   assign tx_gain_sel  = txg_q[GAIN_W];
   assign tx_gain_code = txg_q[GAIN_W-1:0];
endmodule

// File: rtl/spi_cfg_port_chk.sv
module spi_cfg_port_chk #(
   parameter int unsigned GAIN_W = 6,
   parameter logic [GAIN_W-1:0] RX_GAIN_RST = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              spi_sen_n,
   input logic              spi_sclk,
   input logic              sdio_out,
   input logic              sdio_oe,
   input logic              sdo_out,
   input logic              sdo_oe,
   input logic              rx_gain_sel,
   input logic [GAIN_W-1:0] rx_gain_code,
   input logic              tx_gain_sel,
   input logic [GAIN_W-1:0] tx_gain_code,
   input logic              wr_en,
   input logic              srst
);
   logic       c_sclk_q;
   logic [4:0] c_cnt;
   logic       c_rise;
   logic       c_fall;
   logic       drv;
   logic       dat;

   assign c_rise = spi_sclk & ~c_sclk_q;
   assign c_fall = ~spi_sclk & c_sclk_q;
   assign drv    = sdio_oe | sdo_oe;
   assign dat    = sdio_oe ? sdio_out : sdo_out;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_sclk_q <= 1'b0;
         c_cnt    <= '0;
      end else begin
         c_sclk_q <= spi_sclk;
         if (spi_sen_n)                         c_cnt <= '0;
         else if (c_rise && c_cnt != 5'd16)     c_cnt <= c_cnt + 1'b1;
      end
   end

   // R2: a register write happens only on the 16th rising edge of an access
   p_commit_last_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (c_rise && !spi_sen_n && c_cnt == 5'd15));

   // R3: read data only moves in the clock after a serial falling edge
   p_out_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (drv && $past(drv) && !$past(c_fall)) |-> $stable(dat));

   // R4: output drivers are released once the select goes high
   p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      spi_sen_n |=> !(sdio_oe || sdo_oe));

   // R7: software reset bit clears itself and restores defaults
   p_srst_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (!srst && rx_gain_code == RX_GAIN_RST && !rx_gain_sel));

   // R9: registers hold while no access is under way
   p_quiet_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_sen_n && $past(spi_sen_n) && $past(spi_sen_n, 2)) |->
      ($stable(rx_gain_code) && $stable(tx_gain_code) &&
       $stable(rx_gain_sel) && $stable(tx_gain_sel)));
endmodule

bind spi_cfg_port spi_cfg_port_chk #(
   .GAIN_W     (GAIN_W),
   .RX_GAIN_RST(RX_GAIN_RST)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .spi_sen_n   (spi_sen_n),
   .spi_sclk    (spi_sclk),
   .sdio_out    (sdio_out),
   .sdio_oe     (sdio_oe),
   .sdo_out     (sdo_out),
   .sdo_oe      (sdo_oe),
   .rx_gain_sel (rx_gain_sel),
   .rx_gain_code(rx_gain_code),
   .tx_gain_sel (tx_gain_sel),
   .tx_gain_code(tx_gain_code),
   .wr_en       (wr_en),
   .srst        (srst)
);

// File: tb/spi_cfg_port_test.sv
`timescale 1ns/1ps
module spi_cfg_port_test;
   localparam logic [5:0] RXD = 6'h2A;
   localparam logic [5:0] TXD = 6'h11;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sen_n = 1'b1;
   logic       sclk = 1'b0;
   logic       sdio_in = 1'b0;
   logic       sdio_out, sdio_oe, sdo_out, sdo_oe;
   logic       rx_sel, tx_sel;
   logic [5:0] rx_code, tx_code;

   int n_chk = 0;
   int n_fail = 0;
   logic [7:0] m [32];

   always #2.5 clk = ~clk;

   spi_cfg_port #(.ADDR_W(5), .GAIN_W(6), .RX_GAIN_RST(RXD), .TX_GAIN_RST(TXD)) uut (
      .clk(clk), .rst_n(rst_n), .spi_sen_n(sen_n), .spi_sclk(sclk),
      .sdio_in(sdio_in), .sdio_out(sdio_out), .sdio_oe(sdio_oe),
      .sdo_out(sdo_out), .sdo_oe(sdo_oe),
      .rx_gain_sel(rx_sel), .rx_gain_code(rx_code),
      .tx_gain_sel(tx_sel), .tx_gain_code(tx_code)
   );

   function automatic logic [7:0] mask_of(int a);
      if (a == 0) return 8'hE0;
      if (a == 9 || a == 10) return 8'h7F;
      return 8'h00;
   endfunction

   function automatic logic [7:0] def_of(int a);
      if (a == 9) return {2'b00, RXD};
      if (a == 10) return {2'b00, TXD};
      return 8'h00;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < 32; i++) m[i] = def_of(i);
   endtask

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic xfer(input logic rd, input logic [4:0] a, input logic [7:0] wd,
                       input int nbits, output logic [7:0] rdv, output logic oe_ok);
      logic [7:0] ins;
      logic lsb, fw;
      ins = {rd, 2'b00, a};
      lsb = m[0][6];
      fw  = m[0][7];
      rdv = 8'h00;
      oe_ok = 1'b1;
      sen_n = 1'b0;
      wait_clk(4);
      for (int i = 0; i < nbits; i++) begin
         int idx;
         idx = lsb ? (i % 8) : (7 - (i % 8));
         if (i < 8)       sdio_in = ins[idx];
         else if (i < 16) sdio_in = wd[idx];
         else             sdio_in = 1'($urandom);
         wait_clk(4);
         if (rd && i >= 8 && i < 16) begin
            if (fw) begin
               if (!(sdo_oe && !sdio_oe)) oe_ok = 1'b0;
               rdv[idx] = sdo_out;
            end else begin
               if (!(sdio_oe && !sdo_oe)) oe_ok = 1'b0;
               rdv[idx] = sdio_out;
            end
         end else if (i < 16) begin
            if (sdio_oe || sdo_oe) oe_ok = 1'b0;
         end
         sclk = 1'b1;
         wait_clk(4);
         sclk = 1'b0;
      end
      wait_clk(4);
      sen_n = 1'b1;
      wait_clk(4);
      if (sdio_oe || sdo_oe) oe_ok = 1'b0;
      if (!rd && nbits >= 16) begin
         m[a] = wd & mask_of(a);
         if (a == 0 && wd[5]) model_reset();
      end
   endtask

   task automatic do_write(logic [4:0] a, logic [7:0] wd, int nbits, string req);
      logic [7:0] r;
      logic ok;
      logic fw;
      fw = m[0][7];
      xfer(1'b0, a, wd, nbits, r, ok);
      check({req, fw ? "/R5 write no drive" : "/R4 write no drive"}, 32'(ok), 32'd1);
   endtask

   task automatic do_read(logic [4:0] a, string req);
      logic [7:0] r;
      logic ok;
      logic [7:0] exp;
      logic fw;
      fw  = m[0][7];
      exp = m[a];
      xfer(1'b1, a, 8'h00, 16, r, ok);
      check({req, " read data"}, 32'(r), 32'(exp));
      check(fw ? "R5 read drive" : "R4 read drive", 32'(ok), 32'd1);
   endtask

   task automatic check_gains(string req);
      check({req, "/R10 rx code"}, 32'(rx_code), 32'(m[9][5:0]));
      check({req, "/R10 rx sel"},  32'(rx_sel),  32'(m[9][6]));
      check({req, "/R10 tx code"}, 32'(tx_code), 32'(m[10][5:0]));
      check({req, "/R10 tx sel"},  32'(tx_sel),  32'(m[10][6]));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      model_reset();
      wait_clk(6);
      // R1: reset state
      check("R1 sdio_oe", 32'(sdio_oe), 32'd0);
      check("R1 sdo_oe",  32'(sdo_oe),  32'd0);
      check_gains("R1");
      rst_n = 1'b1;
      wait_clk(4);
      check_gains("R1 after release");

      // R2 / R3: plain MSB-first write and read
      do_write(5'd9, 8'h45, 16, "R2");
      check_gains("R2");
      do_read(5'd9, "R3");
      do_write(5'd10, 8'h6E, 16, "R2");
      do_read(5'd10, "R3");

      // R8: unused bits and unmapped addresses
      do_write(5'd9, 8'hFF, 16, "R8");
      do_read(5'd9, "R8");
      do_write(5'd3, 8'hAA, 16, "R8");
      do_read(5'd3, "R8");
      do_write(5'd0, 8'h1F, 16, "R8");
      do_read(5'd0, "R8");

      // R9: aborted writes change nothing
      do_write(5'd10, 8'h01, 12, "R9");
      do_read(5'd10, "R9");
      do_write(5'd10, 8'h02, 15, "R9");
      do_read(5'd10, "R9");
      check_gains("R9");

      // R11: extra clocks after the 16th edge are ignored
      do_write(5'd10, 8'h33, 20, "R11");
      do_read(5'd10, "R11");
      check_gains("R11");

      // R6: LSB-first shifting
      do_write(5'd0, 8'h40, 16, "R6");
      do_write(5'd9, 8'h2C, 16, "R6");
      do_read(5'd9, "R6");
      do_read(5'd0, "R6");

      // R5: 4-wire mode, LSB then MSB first
      do_write(5'd0, 8'hC0, 16, "R5");
      do_read(5'd10, "R5");
      do_write(5'd0, 8'h80, 16, "R5");
      do_read(5'd9, "R5");

      // R7: software reset from 4-wire mode returns to defaults
      do_write(5'd0, 8'hA0, 16, "R7");
      check_gains("R7");
      do_read(5'd0, "R7");
      do_read(5'd9, "R7");

      // Random mix, including random control-register values
      for (int k = 0; k < 160; k++) begin
         int sel;
         logic [4:0] a;
         sel = int'($urandom % 6);
         case (sel)
            0:       a = 5'd0;
            1, 2:    a = 5'd9;
            3, 4:    a = 5'd10;
            default: a = 5'($urandom);
         endcase
         if ($urandom % 2 == 0) begin
            do_write(a, 8'($urandom), 16, "R2");
            check_gains("R2 random");
         end else begin
            do_read(a, m[0][6] ? "R6" : "R3");
         end
      end

      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule